// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder

This block is the serial front end of a quad-channel converter register bank. It watches the two bus lines, SCL and SDA, from the system clock domain. Each line passes through a synchronizer and a glitch filter before the block looks for START, STOP and clock edges. The block drives SDA only by pulling it low. It decodes frames of three bytes: a device address, a command and a data byte. Each accepted operation leaves as a single-cycle request to the register bank. The request names the target (one channel, the control word or every channel), which copies it touches (live, persistent or both) and whether it is a persistent-to-live transfer.

For a read, the master first writes a read-setup command. It then issues a repeated START and the address with the read bit set. The block presents the selected target on `rd_target` and `rd_persist`, samples `rd_data` once, and shifts that byte out MSB first.

The request channel carries only a valid strobe. The bus cannot be paused, so there is no back-pressure: the register bank must take `req_*` in the cycle `req_valid` is high. `rd_data` must be a combinational view of the register named by `rd_target` and `rd_persist`.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The block acknowledges only the address byte {010, strap_addr[3:0], rw}, with rw=0 for write and rw=1 for read. Any other address, including the all-zero general call, is NACKed and produces no request.
- R2: Command 0x1s (C7:C6=00, C5:C4=01, low nibble s = channel 0 to NUM_CH-1, or 4 for the control word) followed by a data byte gives one request: req_live=1, req_persist=0, req_xfer=0, req_target=s, req_data=the data byte.
- R3: Commands 0x2s and 0x3s write the persistent copy (req_persist=1) and, for 0x3s, the live copy as well (req_live=1), with the same target and data rules as R2.
- R4: Target 0xF (all channels) is accepted only as 0x1F. Commands 0x0F, 0x2F and 0x3F are NACKed and produce no request.
- R5: Command 0x0s is a persistent-to-live transfer. It needs no data byte and gives one request with req_xfer=1, req_live=0 and req_persist=0 on the rising SCL edge of the command's acknowledge clock.
- R6: A write request is issued on the 26th SCL rising edge of the frame, which samples the last data bit. A STOP before that edge produces no request.
- R7: Commands other than 0x0s, 0x1s, 0x2s, 0x3s, 0x1F, 0x9s and 0xAs (s = a valid target) are NACKed and produce no request.
- R8: After read setup 0x9s (live) or 0xAs (persistent), a repeated START and the read address, the block acknowledges and returns rd_data for target s, MSB first. A read issues no request.
- R9: A read address that is not preceded, in the same frame, by an accepted read setup is NACKed.
- R10: A STOP inside the same SCL-high period as a START is ignored, so the frame opened by that START goes on.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks after synchronization is ignored.
- R12: On an acknowledge, SDA is held low for the whole high phase of the ninth clock.
- R13: After reset, SDA is released and req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_addr | input | 4 | Low four bits of the device address |
| req_valid | output | 1 | One-cycle request strobe |
| req_xfer | output | 1 | Request is a persistent-to-live transfer |
| req_persist | output | 1 | Request writes the persistent copy |
| req_live | output | 1 | Request writes the live copy |
| req_target | output | 4 | 0..NUM_CH-1 channel, 4 control word, 15 all channels |
| req_data | output | 8 | Data byte for a write |
| rd_persist | output | 1 | Read source is the persistent copy |
| rd_target | output | 4 | Read target |
| rd_data | input | 8 | Register value selected by rd_target and rd_persist |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except for the deliberate START and STOP edges. They also assume every SCL half-period lasts longer than the synchronizer and filter delay, so that each filtered edge is separated from the next. The stimulus uses half-periods of twelve system clocks and moves SDA midway through the low phase. The only short pulse it applies is the deliberate SCL glitch. The bench drives rd_data combinationally from rd_target and rd_persist, as a register bank would.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DATA, ST_RDATA, ST_WAIT
  } eng_st_t;

  localparam logic [2:0] ADDR_PREFIX = 3'b010;
  localparam logic [3:0] SEL_CTRL    = 4'h4;
  localparam logic [3:0] SEL_ALL     = 4'hF;

  // target is a channel below nch or the control word
  function automatic logic target_ok(input logic [3:0] t, input logic [3:0] nch);
    return (t < nch) || (t == SEL_CTRL);
  endfunction

  function automatic logic cmd_legal(input logic [7:0] c, input logic [3:0] nch);
    logic ok;
    case (c[7:6])
      2'b00:   ok = target_ok(c[3:0], nch) || (c[5:4] == 2'b01 && c[3:0] == SEL_ALL);
      2'b10:   ok = (c[5:4] == 2'b01 || c[5:4] == 2'b10) && target_ok(c[3:0], nch);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic cmd_is_xfer(input logic [7:0] c);
    return c[7:4] == 4'b0000;
  endfunction

  function automatic logic cmd_is_rdset(input logic [7:0] c);
    return c[7:6] == 2'b10;
  endfunction

endpackage

// File: rtl/i2cs_line_filt.sv
module i2cs_line_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      cnt      <= '0;
      line_out <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      if (synced == line_out) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        line_out <= synced;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_out != $past(line_out)) |-> (line_out == $past(synced)));

endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d, start_in_high, stop_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d         <= 1'b1;
      sda_d         <= 1'b1;
      start_in_high <= 1'b0;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
      if (start_ev)      start_in_high <= 1'b1;
      else if (scl_fall) start_in_high <= 1'b0;
    end
  end

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_ev = scl & scl_d & sda_d & ~sda;
  assign stop_raw = scl & scl_d & ~sda_d & sda;
  // a stop in the same high phase as a start is not a legal frame end
  assign stop_ev  = stop_raw & ~start_in_high;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [3:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       req_valid,
  output logic       req_xfer,
  output logic       req_persist,
  output logic       req_live,
  output logic [3:0] req_target,
  output logic [7:0] req_data,
  output logic       rd_persist,
  output logic [3:0] rd_target
);
  localparam logic [3:0] NCH = 4'(NUM_CH);

  eng_st_t    st;
  logic [3:0] bitcnt;
  logic [7:0] sr, cmd_q, txsr;
  logic       ack_q, rw_q, rd_pend, ack_now, rx_st;

  assign rx_st      = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_DATA);
  assign rd_target  = cmd_q[3:0];
  assign rd_persist = cmd_q[5];

  always_comb begin
    case (st)
      ST_ADDR: ack_now = (sr[7:1] == {ADDR_PREFIX, strap}) && (!sr[0] || rd_pend);
      ST_CMD:  ack_now = cmd_legal(sr, NCH);
      ST_DATA: ack_now = 1'b1;
      default: ack_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      sr          <= '0;
      cmd_q       <= '0;
      txsr        <= '0;
      ack_q       <= 1'b0;
      rw_q        <= 1'b0;
      rd_pend     <= 1'b0;
      sda_pull    <= 1'b0;
      req_valid   <= 1'b0;
      req_xfer    <= 1'b0;
      req_persist <= 1'b0;
      req_live    <= 1'b0;
      req_target  <= '0;
      req_data    <= '0;
    end else begin
      req_valid <= 1'b0;
      if (stop_ev) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        rd_pend  <= 1'b0;
      end else if (start_ev) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (rx_st) begin
          if (bitcnt < 4'd8) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (st == ST_DATA && bitcnt == 4'd7) begin
              // last data bit: the write is committed here
              req_valid   <= 1'b1;
              req_xfer    <= 1'b0;
              req_persist <= cmd_q[5];
              req_live    <= cmd_q[4];
              req_target  <= cmd_q[3:0];
              req_data    <= {sr[6:0], sda_s};
            end
          end else begin
            bitcnt <= 4'd9;
            if (st == ST_CMD && ack_q && cmd_is_xfer(cmd_q)) begin
              req_valid   <= 1'b1;
              req_xfer    <= 1'b1;
              req_persist <= 1'b0;
              req_live    <= 1'b0;
              req_target  <= cmd_q[3:0];
              req_data    <= '0;
            end
          end
        end else if (st == ST_RDATA) begin
          bitcnt <= (bitcnt < 4'd8) ? bitcnt + 1'b1 : 4'd9;
        end
      end else if (scl_fall) begin
        if (rx_st) begin
          if (bitcnt == 4'd8) begin
            ack_q    <= ack_now;
            sda_pull <= ack_now;
            if (st == ST_ADDR) rw_q  <= sr[0];
            if (st == ST_CMD)  cmd_q <= sr;
          end else if (bitcnt == 4'd9) begin
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            if (!ack_q) begin
              st <= ST_WAIT;
            end else begin
              case (st)
                ST_ADDR: begin
                  if (rw_q) begin
                    st       <= ST_RDATA;
                    txsr     <= rd_data;
                    sda_pull <= ~rd_data[7];
                    rd_pend  <= 1'b0;
                  end else begin
                    st <= ST_CMD;
                  end
                end
                ST_CMD: begin
                  if (cmd_is_rdset(cmd_q)) begin
                    rd_pend <= 1'b1;
                    st      <= ST_WAIT;
                  end else if (cmd_is_xfer(cmd_q)) begin
                    st <= ST_WAIT;
                  end else begin
                    st <= ST_DATA;
                  end
                end
                default: st <= ST_WAIT;
              endcase
            end
          end
        end else if (st == ST_RDATA) begin
          if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            txsr     <= {txsr[6:0], 1'b0};
            sda_pull <= ~txsr[6];
          end else if (bitcnt == 4'd8) begin
            sda_pull <= 1'b0;
            st       <= ST_WAIT;
          end
        end
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R4
  all_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_target == SEL_ALL) |-> (req_live && !req_persist && !req_xfer));

  // R5
  xfer_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_xfer == (!req_persist && !req_live)));

  // R12
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull));

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [3:0] strap_addr,
  output logic       req_valid,
  output logic       req_xfer,
  output logic       req_persist,
  output logic       req_live,
  output logic [3:0] req_target,
  output logic [7:0] req_data,
  output logic       rd_persist,
  output logic [3:0] rd_target,
  input  logic [7:0] rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_l, filt_l;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_l = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cs_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_in(raw_l[g]), .line_out(filt_l[g]));
  end

  i2cs_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(filt_l[0]), .sda(filt_l[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2cs_engine #(.NUM_CH(NUM_CH)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(filt_l[0]), .sda_s(filt_l[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_addr), .rd_data(rd_data), .sda_pull(sda_pull),
    .req_valid(req_valid), .req_xfer(req_xfer), .req_persist(req_persist),
    .req_live(req_live), .req_target(req_target), .req_data(req_data),
    .rd_persist(rd_persist), .rd_target(rd_target));

endmodule

// File: tb/sim_i2c_cmd_slave.sv
module sim_i2c_cmd_slave;
  localparam int HB = 12;
  localparam logic [3:0] STRAP = 4'h5;
  localparam logic [7:0] AW = {3'b010, STRAP, 1'b0};
  localparam logic [7:0] AR = {3'b010, STRAP, 1'b1};
  localparam int NV = 13;
  // {command, data, expected command ack, expected request}
  localparam logic [17:0] VEC [0:NV-1] = '{
    {8'h10, 8'h5A, 1'b1, 1'b1},  // R2
    {8'h21, 8'hA5, 1'b1, 1'b1},  // R3
    {8'h33, 8'h3C, 1'b1, 1'b1},  // R3
    {8'h14, 8'h81, 1'b1, 1'b1},  // R2 control word
    {8'h1F, 8'hFF, 1'b1, 1'b1},  // R4
    {8'h2F, 8'h11, 1'b0, 1'b0},  // R4
    {8'h02, 8'h00, 1'b1, 1'b1},  // R5
    {8'h0F, 8'h00, 1'b0, 1'b0},  // R4
    {8'h45, 8'h00, 1'b0, 1'b0},  // R7
    {8'h15, 8'h00, 1'b0, 1'b0},  // R7
    {8'hB0, 8'h00, 1'b0, 1'b0},  // R7
    {8'h92, 8'h00, 1'b1, 1'b0},  // R8 setup only
    {8'hC0, 8'h00, 1'b0, 1'b0}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, req_valid, req_xfer, req_persist, req_live, rd_persist;
  logic [3:0] req_target, rd_target;
  logic [7:0] req_data, rd_data;
  wire  sda_bus = sda_m & ~sda_pull;
  int total = 0, bad = 0, nreq = 0;
  logic c_xfer, c_persist, c_live;
  logic [3:0] c_target;
  logic [7:0] c_data;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign rd_data = {rd_persist, 3'b000, rd_target} ^ 8'hC3;

  i2c_cmd_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull),
    .strap_addr(STRAP), .req_valid(req_valid), .req_xfer(req_xfer),
    .req_persist(req_persist), .req_live(req_live), .req_target(req_target),
    .req_data(req_data), .rd_persist(rd_persist), .rd_target(rd_target),
    .rd_data(rd_data));

  always @(negedge clk) if (rst_n && req_valid) begin
    nreq++;
    c_xfer = req_xfer; c_persist = req_persist; c_live = req_live;
    c_target = req_target; c_data = req_data;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(HB/2); sda_m = 1'b1; tick(HB/2);
    scl_m = 1'b1; tick(HB); sda_m = 1'b0; tick(HB); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; tick(HB/2); sda_m = 1'b0; tick(HB/2);
    scl_m = 1'b1; tick(HB); sda_m = 1'b1; tick(HB);
  endtask

  task automatic send_bit(input logic b);
    scl_m = 1'b0; tick(HB/2); sda_m = b; tick(HB/2);
    scl_m = 1'b1; tick(HB); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl_m = 1'b0; tick(HB/2); sda_m = 1'b1; tick(HB/2);
    scl_m = 1'b1; tick(2); a1 = ~sda_bus; tick(HB-2); a2 = ~sda_bus;
    scl_m = 1'b0;
    ack = a1 & a2;
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      scl_m = 1'b0; tick(HB/2); sda_m = 1'b1; tick(HB/2);
      scl_m = 1'b1; tick(HB/2); b = {b[6:0], sda_bus}; tick(HB/2);
    end
    scl_m = 1'b0;
    send_bit(1'b1);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] got;
    int n0 = nreq;
    bus_start(); write_byte(AW, a); write_byte(cmd, a);
    chk(a, {tag, " setup ack"}, a, 1);
    bus_start(); write_byte(AR, a);
    chk(a, {tag, " read address ack"}, a, 1);
    read_byte(got); bus_stop();
    chk(got == exp, {tag, " read data"}, got, exp);
    chk(nreq == n0, {tag, " no request on read"}, nreq - n0, 0);
  endtask

  initial begin
    logic a;
    int n0;
    tick(5);
    // R13 reset state
    chk(sda_pull == 1'b0, "R13 sda released in reset", sda_pull, 0);
    chk(req_valid == 1'b0, "R13 no request in reset", req_valid, 0);
    rst_n = 1'b1; tick(5);
    chk(sda_pull == 1'b0 && req_valid == 1'b0, "R13 idle after reset", sda_pull, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd, dat;
      logic eack, ereq, sdat;
      {cmd, dat, eack, ereq} = VEC[v];
      sdat = (cmd[7:6] == 2'b00) && (cmd[5:4] != 2'b00);
      n0 = nreq;
      bus_start(); write_byte(AW, a);
      chk(a, "R1 R12 address ack", a, 1);
      write_byte(cmd, a);
      chk(a == eack, $sformatf("R7 table %0d command ack", v), a, eack);
      if (a && sdat) write_byte(dat, a);
      bus_stop();
      chk((nreq - n0) == int'(ereq), $sformatf("R2 R3 R4 R5 table %0d request count", v), nreq - n0, ereq);
      if (ereq && nreq - n0 == 1) begin
        chk(c_target == cmd[3:0], $sformatf("R2 table %0d target", v), c_target, cmd[3:0]);
        chk(c_persist == cmd[5] && c_live == cmd[4], $sformatf("R3 table %0d copies", v),
            {c_persist, c_live}, cmd[5:4]);
        chk(c_xfer == (cmd[5:4] == 2'b00), $sformatf("R5 table %0d transfer flag", v), c_xfer, cmd[5:4] == 2'b00);
        if (sdat) chk(c_data == dat, $sformatf("R6 table %0d data", v), c_data, dat);
      end
    end

    // R1 wrong strap value and general call
    n0 = nreq;
    bus_start(); write_byte({3'b010, 4'h6, 1'b0}, a); bus_stop();
    chk(!a, "R1 foreign address nack", a, 0);
    bus_start(); write_byte(8'h00, a); bus_stop();
    chk(!a, "R1 general call nack", a, 0);
    chk(nreq == n0, "R1 no request", nreq - n0, 0);

    // R6 abort in the middle of the data byte
    n0 = nreq;
    bus_start(); write_byte(AW, a); write_byte(8'h11, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    chk(nreq == n0, "R6 aborted frame no request", nreq - n0, 0);

    // R8 reads of live and persistent copies
    do_read(8'h92, 8'h02 ^ 8'hC3, "R8 live ch2");
    do_read(8'hA1, 8'h81 ^ 8'hC3, "R8 persist ch1");

    // R9 read address without setup
    bus_start(); write_byte(AR, a); bus_stop();
    chk(!a, "R9 read without setup nack", a, 0);

    // R10 stop in the same high phase as start is ignored
    n0 = nreq;
    sda_m = 1'b1; scl_m = 1'b1; tick(HB);
    sda_m = 1'b0; tick(HB); sda_m = 1'b1; tick(HB); scl_m = 1'b0;
    write_byte(AW, a);
    chk(a, "R10 frame continues after illegal stop", a, 1);
    write_byte(8'h13, a); write_byte(8'h77, a); bus_stop();
    chk(nreq - n0 == 1 && c_data == 8'h77, "R10 write after illegal stop", c_data, 8'h77);

    // R11 short SCL glitch is not counted as a clock
    n0 = nreq;
    bus_start(); write_byte(AW, a);
    scl_m = 1'b0; tick(HB); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(HB);
    write_byte(8'h10, a);
    chk(a, "R11 command ack after glitch", a, 1);
    write_byte(8'h66, a); bus_stop();
    chk(nreq - n0 == 1 && c_data == 8'h66 && c_target == 4'h0, "R11 write after glitch", c_data, 8'h66);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule